// File: doc/BRIEF.md
# Remote queue address translator

This block sits on the receive side of a network endpoint and converts short-message enqueues into host-memory write addresses. A message names a destination queue by number, not by address. The block keeps a table of circular queue descriptors. Each descriptor holds a 64-bit physical base, a 32-bit write offset (the head) and a 32-bit wrap limit. For every accepted message it returns the queue's current write address and moves that queue's head forward by the message size. When the head reaches the wrap limit, it goes back to the start of the buffer.

Software fills in and inspects the descriptors through a simple register-style port that selects one field of one entry at a time. Many senders can target the same queue, and the enqueue port takes one message per cycle. Back-to-back messages to the same queue each get their own slot, in the order they were accepted. If a configuration write lands on the entry an enqueue is asking for in that same cycle, the write goes first and the enqueue waits one cycle.

Top module: `remote_queue_xlat`

## Requirements
- R1: After synchronous reset, rsp_valid and cfg_rvalid are low, enq_ready is high, and every queue's head reads back as 0.
- R2: cfg_sel picks the field: 0 is the 64-bit base, 1 is the head (low 32 bits of cfg_wdata), 2 is the wrap limit (low 32 bits). A read of the head or the wrap limit returns it zero-extended. Value 3 reads as 0, and writes to it change nothing. Read data appears, with cfg_rvalid high, in the cycle after the cycle in which cfg_re is high.
- R3: A message is accepted on a clock edge where enq_valid and enq_ready are both high. In the cycle after the next edge, rsp_valid is high and the response carries the message's queue number and the address base + head, using the head as it stood before this message advanced it.
- R4: Accepting a message of enq_len bytes (1 to 64) adds the length rounded up to a multiple of 8 bytes to the queue's head.
- R5: If the advanced head would equal or exceed the wrap limit, the head becomes 0 instead.
- R6: Messages to the same queue accepted on consecutive cycles get consecutive, non-overlapping addresses in acceptance order.
- R7: enq_ready is low exactly when cfg_we is high and cfg_qid equals enq_qid. The configuration write takes effect, and a message accepted later uses the new value.
- R8: A message changes only the head of the queue it names.
- R9: A head write that lands on the same edge as the head update of a message in flight to that queue wins, so the head holds the written value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_sel | input | 2 | Field select (0 base, 1 head, 2 wrap, 3 none) |
| cfg_qid | input | 8 | Table entry to access |
| cfg_wdata | input | 64 | Write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 64 | Read data |
| enq_valid | input | 1 | Message enqueue request |
| enq_ready | output | 1 | Request may be accepted this cycle |
| enq_qid | input | 8 | Destination queue number |
| enq_len | input | 7 | Message length in bytes, 1 to 64 |
| rsp_valid | output | 1 | Address response valid |
| rsp_qid | output | 8 | Queue number of the response |
| rsp_addr | output | 64 | Physical write address for the message |

## Verification
Two events can land in the same cycle: a configuration write and an enqueue that name the same entry, and a head write that lands on the edge where an in-flight message writes back its advanced head. The bench creates the first case on purpose by driving cfg_qid equal to enq_qid, and it also lets random head writes hit the active queues during random traffic. For the first case it checks that enq_ready drops and that the retried message uses the freshly written value. For the second case it reads the head back and compares it against a reference model in which the configuration write is applied last.

// File: rtl/rqat_pkg.sv
package rqat_pkg;

  // Field selector of the configuration port
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_HEAD = 2'd1,
    FLD_WRAP = 2'd2,
    FLD_NONE = 2'd3
  } cfg_field_e;

endpackage

// File: rtl/rqat_advance.sv
// Head advance: round the length up to whole words, add, fold to zero at the limit.
module rqat_advance #(
  parameter int OFF_W      = 32,
  parameter int LEN_W      = 7,
  parameter int WORD_BYTES = 8
) (
  input  logic [OFF_W-1:0] head,
  input  logic [OFF_W-1:0] wrap,
  input  logic [LEN_W-1:0] len,
  output logic [OFF_W-1:0] next_head
);

  localparam logic [LEN_W:0] WMASK = (LEN_W+1)'(WORD_BYTES - 1);

  logic [LEN_W:0] len_up;
  logic [LEN_W:0] step;
  logic [OFF_W:0] sum;

  always_comb begin
    len_up    = {1'b0, len} + WMASK;
    step      = len_up & ~WMASK;
    sum       = {1'b0, head} + (OFF_W+1)'(step);
    next_head = (sum >= {1'b0, wrap}) ? '0 : sum[OFF_W-1:0];
  end

endmodule

// File: rtl/rqat_table.sv
// Descriptor storage. Base and wrap are single-writer memories with
// synchronous reads; the head lives in registers because it has two writers.
module rqat_table
  import rqat_pkg::*;
#(
  parameter int NUM_Q  = 256,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 32,
  parameter int QID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  // configuration side
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_sel,
  input  logic [QID_W-1:0]  cfg_qid,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_rvalid,
  output logic [ADDR_W-1:0] cfg_rdata,
  // enqueue lookup (registered on rd_en)
  input  logic              rd_en,
  input  logic [QID_W-1:0]  rd_qid,
  output logic [ADDR_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_wrap,
  output logic [OFF_W-1:0]  rd_head,
  // head write-back from the advance stage
  input  logic              wb_en,
  input  logic [QID_W-1:0]  wb_qid,
  input  logic [OFF_W-1:0]  wb_head
);

  cfg_field_e sel;
  assign sel = cfg_field_e'(cfg_sel);

  logic [ADDR_W-1:0] base_mem [NUM_Q];
  logic [OFF_W-1:0]  wrap_mem [NUM_Q];
  logic [OFF_W-1:0]  head_q   [NUM_Q];

  logic wr_base, wr_wrap, wr_head;
  assign wr_base = cfg_we && (sel == FLD_BASE);
  assign wr_wrap = cfg_we && (sel == FLD_WRAP);
  assign wr_head = cfg_we && (sel == FLD_HEAD);

  always_ff @(posedge clk) begin
    if (wr_base) base_mem[cfg_qid] <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_wrap) wrap_mem[cfg_qid] <= cfg_wdata[OFF_W-1:0];
  end

  // Head registers: configuration write is applied last and so wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_Q; i++) head_q[i] <= '0;
    end else begin
      if (wb_en)   head_q[wb_qid]  <= wb_head;
      if (wr_head) head_q[cfg_qid] <= cfg_wdata[OFF_W-1:0];
    end
  end

  // Lookup for a newly accepted message; a write-back on this same edge to
  // the same queue is forwarded so back-to-back messages see the new head.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_base <= base_mem[rd_qid];
      rd_wrap <= wrap_mem[rd_qid];
      rd_head <= (wb_en && (wb_qid == rd_qid)) ? wb_head : head_q[rd_qid];
    end
  end

  // Configuration read port
  always_ff @(posedge clk) begin
    if (rst) cfg_rvalid <= 1'b0;
    else     cfg_rvalid <= cfg_re;
  end

  always_ff @(posedge clk) begin
    if (cfg_re) begin
      unique case (sel)
        FLD_BASE: cfg_rdata <= base_mem[cfg_qid];
        FLD_HEAD: cfg_rdata <= ADDR_W'(head_q[cfg_qid]);
        FLD_WRAP: cfg_rdata <= ADDR_W'(wrap_mem[cfg_qid]);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/remote_queue_xlat.sv
module remote_queue_xlat #(
  parameter int NUM_Q      = 256,
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 32,
  parameter int MAX_MSG    = 64,
  parameter int WORD_BYTES = 8,
  localparam int QID_W     = $clog2(NUM_Q),
  localparam int LEN_W     = $clog2(MAX_MSG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [1:0]        cfg_sel,
  input  logic [QID_W-1:0]  cfg_qid,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_rvalid,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [QID_W-1:0]  enq_qid,
  input  logic [LEN_W-1:0]  enq_len,
  output logic              rsp_valid,
  output logic [QID_W-1:0]  rsp_qid,
  output logic [ADDR_W-1:0] rsp_addr
);

  // A configuration write to the requested entry holds the request off.
  logic accept;
  assign enq_ready = !(cfg_we && (cfg_qid == enq_qid));
  assign accept    = enq_valid && enq_ready;

  // Lookup stage
  logic             s1_valid;
  logic [QID_W-1:0] s1_qid;
  logic [LEN_W-1:0] s1_len;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_qid <= enq_qid;
      s1_len <= enq_len;
    end
  end

  logic [ADDR_W-1:0] rd_base;
  logic [OFF_W-1:0]  rd_wrap;
  logic [OFF_W-1:0]  rd_head;
  logic [OFF_W-1:0]  next_head;

  rqat_table #(
    .NUM_Q  (NUM_Q),
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .QID_W  (QID_W)
  ) table_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_re     (cfg_re),
    .cfg_sel    (cfg_sel),
    .cfg_qid    (cfg_qid),
    .cfg_wdata  (cfg_wdata),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata),
    .rd_en      (accept),
    .rd_qid     (enq_qid),
    .rd_base    (rd_base),
    .rd_wrap    (rd_wrap),
    .rd_head    (rd_head),
    .wb_en      (s1_valid),
    .wb_qid     (s1_qid),
    .wb_head    (next_head)
  );

  rqat_advance #(
    .OFF_W      (OFF_W),
    .LEN_W      (LEN_W),
    .WORD_BYTES (WORD_BYTES)
  ) adv_i (
    .head      (rd_head),
    .wrap      (rd_wrap),
    .len       (s1_len),
    .next_head (next_head)
  );

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      rsp_qid  <= s1_qid;
      rsp_addr <= rd_base + ADDR_W'(rd_head);
    end
  end

endmodule

// File: rtl/rqat_chk.sv
module rqat_chk #(
  parameter int QID_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             cfg_re,
  input logic [QID_W-1:0] cfg_qid,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic [QID_W-1:0] enq_qid,
  input logic             rsp_valid,
  input logic             cfg_rvalid
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !cfg_rvalid));

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rvalid |-> $past(cfg_re));

  // R3
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(enq_valid && enq_ready, 2));

  // R7
  collision_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && cfg_we && (cfg_qid == enq_qid)) |-> ##2 !rsp_valid);

endmodule

bind remote_queue_xlat rqat_chk #(.QID_W(QID_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_re     (cfg_re),
  .cfg_qid    (cfg_qid),
  .enq_valid  (enq_valid),
  .enq_ready  (enq_ready),
  .enq_qid    (enq_qid),
  .rsp_valid  (rsp_valid),
  .cfg_rvalid (cfg_rvalid)
);

// File: tb/remote_queue_xlat_tb_top.sv
`timescale 1ns/1ps
module remote_queue_xlat_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_qid = '0;
  logic [63:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [63:0] cfg_rdata;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [7:0]  enq_qid = '0;
  logic [6:0]  enq_len = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_qid;
  logic [63:0] rsp_addr;

  always #2.5 clk = ~clk;

  remote_queue_xlat dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sel(cfg_sel), .cfg_qid(cfg_qid),
    .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_qid(enq_qid),
    .enq_len(enq_len), .rsp_valid(rsp_valid), .rsp_qid(rsp_qid),
    .rsp_addr(rsp_addr)
  );

  int unsigned checks = 0, failures = 0;
  bit          done = 1'b0;

  // Reference model
  logic [63:0] m_base [256];
  logic [31:0] m_head [256];
  logic [31:0] m_wrap [256];

  bit          pend_v = 1'b0;
  logic [7:0]  pend_q = '0;
  logic [63:0] pend_a = '0;
  string       pend_tag = "R3";
  string       cur_tag  = "R3";

  function automatic logic [31:0] f_next(logic [31:0] h, logic [31:0] w, logic [6:0] len);
    logic [32:0] s;
    s = {1'b0, h} + 33'((int'(len) + 7) / 8 * 8);
    return (s >= {1'b0, w}) ? 32'd0 : s[31:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus; checks the response due from the previous accept.
  task automatic cycle(input bit ev, input logic [7:0] eq, input logic [6:0] el,
                       input bit cw, input logic [1:0] cs, input logic [7:0] cq,
                       input logic [63:0] cd);
    bit rdy, acc, nv;
    logic [7:0]  nq;
    logic [63:0] na;
    nv = 1'b0; nq = '0; na = '0;
    enq_valid = ev; enq_qid = eq; enq_len = el;
    cfg_we = cw; cfg_sel = cs; cfg_qid = cq; cfg_wdata = cd;
    #1;
    rdy = !(cw && (cq == eq));
    chk("R7", {63'd0, enq_ready}, {63'd0, rdy});
    acc = ev && rdy;
    if (acc) begin
      nv = 1'b1; nq = eq;
      na = m_base[eq] + {32'd0, m_head[eq]};
      m_head[eq] = f_next(m_head[eq], m_wrap[eq], el);
    end
    if (cw) begin
      case (cs)
        2'd0: m_base[cq] = cd;
        2'd1: m_head[cq] = cd[31:0];
        2'd2: m_wrap[cq] = cd[31:0];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk("R3", {63'd0, rsp_valid}, {63'd0, pend_v});
    if (pend_v) begin
      chk("R3", {56'd0, rsp_qid}, {56'd0, pend_q});
      chk(pend_tag, rsp_addr, pend_a);
    end
    pend_v = nv; pend_q = nq; pend_a = na; pend_tag = cur_tag;
    enq_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 8'd0, 7'd0, 1'b0, 2'd0, 8'd0, 64'd0);
  endtask

  task automatic enq(input logic [7:0] q, input logic [6:0] len);
    cycle(1'b1, q, len, 1'b0, 2'd0, 8'd0, 64'd0);
  endtask

  task automatic wr(input logic [7:0] q, input logic [1:0] s, input logic [63:0] d);
    cycle(1'b0, 8'd0, 7'd0, 1'b1, s, q, d);
  endtask

  task automatic rd(input logic [7:0] q, input logic [1:0] s, input string tag);
    logic [63:0] e;
    idle();
    idle();
    case (s)
      2'd0: e = m_base[q];
      2'd1: e = {32'd0, m_head[q]};
      2'd2: e = {32'd0, m_wrap[q]};
      default: e = 64'd0;
    endcase
    cfg_re = 1'b1; cfg_sel = s; cfg_qid = q;
    @(posedge clk); #1;
    chk("R2", {63'd0, cfg_rvalid}, 64'd1);
    chk(tag, cfg_rdata, e);
    cfg_re = 1'b0;
  endtask

  task automatic setup(input logic [7:0] q, input logic [63:0] b, input logic [31:0] w,
                       input logic [31:0] h);
    wr(q, 2'd0, b);
    wr(q, 2'd2, {32'd0, w});
    wr(q, 2'd1, {32'd0, h});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_base[i] = '0; m_head[i] = '0; m_wrap[i] = '0;
    end
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    chk("R1", {63'd0, rsp_valid}, 64'd0);
    chk("R1", {63'd0, cfg_rvalid}, 64'd0);
    chk("R1", {63'd0, enq_ready}, 64'd1);
    rd(8'd0, 2'd1, "R1");
    rd(8'd255, 2'd1, "R1");

    // R2: field access and the unused selector
    setup(8'd5, 64'h0123_4567_89AB_CDE8, 32'h0000_1000, 32'h0000_0040);
    rd(8'd5, 2'd0, "R2");
    rd(8'd5, 2'd1, "R2");
    rd(8'd5, 2'd2, "R2");
    wr(8'd5, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'd5, 2'd3, "R2");
    rd(8'd5, 2'd0, "R2");
    rd(8'd5, 2'd1, "R2");

    // R3 and R4: address and rounding
    cur_tag = "R3";
    setup(8'd1, 64'h0000_1000_0000_0000, 32'd4096, 32'd0);
    enq(8'd1, 7'd1);  idle();
    cur_tag = "R4";
    enq(8'd1, 7'd8);  idle();
    enq(8'd1, 7'd9);  idle();
    enq(8'd1, 7'd64); idle();
    rd(8'd1, 2'd1, "R4");

    // R6: back-to-back on one queue
    cur_tag = "R6";
    enq(8'd1, 7'd17); enq(8'd1, 7'd3); enq(8'd1, 7'd64); enq(8'd1, 7'd40);
    idle();
    rd(8'd1, 2'd1, "R6");

    // R5: wrap to zero, exact and overshoot
    cur_tag = "R5";
    setup(8'd2, 64'h0000_0000_8000_0000, 32'd64, 32'd48);
    enq(8'd2, 7'd16); enq(8'd2, 7'd8); idle();
    rd(8'd2, 2'd1, "R5");
    wr(8'd2, 2'd1, 64'd40);
    enq(8'd2, 7'd33); enq(8'd2, 7'd1); idle();
    rd(8'd2, 2'd1, "R5");

    // R8: another queue's head unchanged
    rd(8'd5, 2'd1, "R8");

    // R7: collision stall, then retry uses new base
    cur_tag = "R7";
    setup(8'd3, 64'h0000_0000_0000_1000, 32'd1024, 32'd0);
    cycle(1'b1, 8'd3, 7'd8, 1'b1, 2'd0, 8'd3, 64'h0000_0000_0000_9000);
    enq(8'd3, 7'd8);
    cycle(1'b1, 8'd3, 7'd8, 1'b1, 2'd0, 8'd4, 64'h0000_0000_0000_2000);
    idle();

    // R9: head write collides with in-flight write-back
    cur_tag = "R9";
    setup(8'd4, 64'h0000_0000_0000_2000, 32'd4096, 32'd0);
    enq(8'd4, 7'd8);
    cycle(1'b0, 8'd0, 7'd0, 1'b1, 2'd1, 8'd4, 64'h200);
    rd(8'd4, 2'd1, "R9");
    enq(8'd4, 7'd8); idle();

    // Random traffic over eight queues
    cur_tag = "R6";
    for (int q = 0; q < 8; q++) begin
      logic [63:0] b;
      b = {$urandom, $urandom} & ~64'd7;
      setup(8'(q), b, 32'(64 + 8 * $urandom_range(0, 56)), 32'd0);
    end
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  q, cq;
      logic [6:0]  ln;
      logic [63:0] cd;
      bit          ev, cw;
      q  = 8'($urandom_range(0, 7));
      ln = 7'($urandom_range(1, 64));
      ev = ($urandom_range(0, 3) != 0);
      cw = ($urandom_range(0, 7) == 0);
      cq = 8'($urandom_range(0, 7));
      cd = 64'(8 * $urandom_range(0, m_wrap[cq] / 8 - 1));
      cycle(ev, q, ln, cw, 2'd1, cq, cd);
    end
    idle();
    for (int q = 0; q < 8; q++) rd(8'(q), 2'd1, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule